// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three 16-bit down counters behind a byte-wide port interface with four addresses: one data port per channel and one control port. Software writes a packed control byte to pick a channel, its byte access order and its operating mode, then writes the count through that channel's data port. Each counter steps once per cycle in which the shared tick enable is high.

Two modes are implemented. The one-shot mode drives the channel output low when it is programmed and raises it when the count expires. The rate mode reloads the count by itself and drops the output for one tick in each period. Any other mode code behaves as the one-shot mode, and the BCD flag has no effect. A loaded count of zero stands for 65536 ticks.

A counter's value can be read live, or frozen first with a per-channel latch command or with a read-back command that names several channels at once. Channel 2 counts only while its gate input is high. Its output level can be read as bit 5 of a read at the control port.

Top module: `interval_timer`

## Requirements
- R1: After reset every output in `out_o` is low, a read at the control port (address 3) returns 0x00, and no channel counts until it has been programmed.
- R2: A control byte written to address 3 is decoded as follows. Bits 7:6 select the channel (0, 1 or 2). Bits 5:4 give the access mode (0 latch, 1 low byte only, 2 high byte only, 3 low byte then high byte). Bits 3:1 give the operating mode: 2 selects rate mode and every other code selects one-shot mode. Bit 0 (BCD) is ignored, so counting is always binary.
- R3: In access mode 3, the first data write sets the low byte and the second sets the high byte. The new count N is loaded on the first tick after the high byte is written, and each later tick decrements it by one.
- R4: In one-shot mode, writing the control byte drives the output low. After the load tick, the output goes high on the Nth tick and then stays high until the channel is written again.
- R5: In rate mode the output is high after the control write. With a count N of 2 or more, it goes low on the tick that brings the count to 1 and goes high again on the next tick, which also reloads N. The period is therefore N ticks, with the output low for one tick.
- R6: A loaded count of 0x0000 lasts 65536 ticks. In one-shot mode the output rises 65537 ticks after the high byte is written, counting the load tick.
- R7: A control byte with access mode 0 latches that channel's count. The latched value stays fixed while the counter runs. Reads return the low byte and then the high byte, and the latch is released after the high byte has been read.
- R8: A control byte with bits 7:6 equal to 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2, and bit 5 low requests a count latch. A latch command sent to a channel that already holds a latched value is ignored.
- R9: Channel 2 counts only on ticks for which `gate2_i` is high. While the gate is low, its count does not change.
- R10: The output level of channel 2 appears on `out_o[2]` and as bit 5 of a read at address 3. All other bits of that read are zero.
- R11: In access mode 1, a data write sets the low byte and clears the high byte, and reads return the low byte. In access mode 2, a data write sets the high byte and clears the low byte, and reads return the high byte.
- R12: With no latch held, a data-port read returns the live count, using the byte order of the channel's access mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable shared by all channels |
| gate2_i | input | 1 | Gate of channel 2; high lets it count |
| addr_i | input | 2 | Port select: 0 to 2 are the channel data ports, 3 is the control port |
| wr_i | input | 1 | Byte write strobe |
| rd_i | input | 1 | Byte read strobe; a read advances the read order when the strobe is sampled at the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the same cycle as `rd_i` |
| out_o | output | 3 | Channel output levels |

## Verification
A wrong byte-order flag or a stale pending-load flag changes the moment an output edge happens. Because the bench compares every output on every clock against its own model, such an error is reported in the first cycle the edge lands on the wrong tick. A latch that is not released, or is released early, shows up on the next pair of data-port reads as a byte that does not belong to the expected value. A gate or reload fault appears as a period or terminal-count edge measured in ticks that differs from the value the requirements predict.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int NUM_CH   = 3;
  localparam int BYTE_W   = 8;
  localparam int CNT_W    = 2 * BYTE_W;
  localparam int GATED_CH = 2;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  localparam logic [1:0] ADDR_CTRL = 2'd3;
  localparam logic [2:0] OPM_RATE  = 3'd2;
  localparam int         OUT_BIT   = 5;
endpackage

// File: rtl/pit_decode.sv
module pit_decode
  import pit_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  output logic [NUM_CH-1:0]   ctrl_wr_o,
  output logic [NUM_CH-1:0]   latch_o,
  output logic [NUM_CH-1:0]   data_wr_o,
  output logic [NUM_CH-1:0]   data_rd_o,
  output acc_e                acc_o,
  output logic                rate_o
);
  logic       is_ctrl;
  logic       is_rb;
  logic [1:0] ch_sel;

  assign is_ctrl = wr_i && (addr_i == ADDR_CTRL);
  assign ch_sel  = wdata_i[7:6];
  assign is_rb   = (ch_sel == 2'd3);
  assign acc_o   = acc_e'(wdata_i[5:4]);
  assign rate_o  = (wdata_i[3:1] == OPM_RATE);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    assign hit          = is_ctrl && !is_rb && (ch_sel == 2'(i));
    assign ctrl_wr_o[i] = hit && (wdata_i[5:4] != 2'd0);
    assign latch_o[i]   = (hit && (wdata_i[5:4] == 2'd0)) ||
                          (is_ctrl && is_rb && !wdata_i[5] && wdata_i[i+1]);
    assign data_wr_o[i] = wr_i && (addr_i == 2'(i));
    assign data_rd_o[i] = rd_i && (addr_i == 2'(i));
  end

  assert_one_ch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ctrl_wr_o) && !(|(ctrl_wr_o & latch_o)));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              ctrl_wr_i,
  input  acc_e              acc_i,
  input  logic              rate_i,
  input  logic              latch_i,
  input  logic              data_wr_i,
  input  logic              data_rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              out_o
);
  acc_e             acc_q;
  logic             rate_q, pend_q, run_q, wff_q, rff_q, lat_q, out_q;
  logic [CNT_W-1:0] cnt_q, rld_q, latv_q, rd_val;
  logic             rd_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= ACC_WORD;
      rate_q <= 1'b0;
      pend_q <= 1'b0;
      run_q  <= 1'b0;
      wff_q  <= 1'b0;
      rff_q  <= 1'b0;
      lat_q  <= 1'b0;
      out_q  <= 1'b0;
      cnt_q  <= '0;
      rld_q  <= '0;
      latv_q <= '0;
    end else begin
      if (tick_en_i) begin
        if (pend_q) begin
          cnt_q  <= rld_q;
          pend_q <= 1'b0;
          run_q  <= 1'b1;
        end else if (run_q) begin
          if (rate_q) begin
            if (cnt_q == CNT_W'(1)) begin
              cnt_q <= rld_q;
              out_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q - 1'b1;
              if (cnt_q == CNT_W'(2)) out_q <= 1'b0;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) out_q <= 1'b1;
          end
        end
      end

      if (latch_i && !lat_q) begin
        lat_q  <= 1'b1;
        latv_q <= cnt_q;
      end

      if (data_rd_i) begin
        if (acc_q == ACC_WORD) begin
          rff_q <= ~rff_q;
          if (rff_q) lat_q <= 1'b0;
        end else begin
          lat_q <= 1'b0;
        end
      end

      if (data_wr_i) begin
        out_q <= rate_q;
        unique case (acc_q)
          ACC_LO: begin
            rld_q  <= {{BYTE_W{1'b0}}, wdata_i};
            pend_q <= 1'b1;
            run_q  <= 1'b0;
          end
          ACC_HI: begin
            rld_q  <= {wdata_i, {BYTE_W{1'b0}}};
            pend_q <= 1'b1;
            run_q  <= 1'b0;
          end
          default: begin
            if (!wff_q) begin
              rld_q[BYTE_W-1:0] <= wdata_i;
              wff_q  <= 1'b1;
              pend_q <= 1'b0;
              run_q  <= 1'b0;
            end else begin
              rld_q[CNT_W-1:BYTE_W] <= wdata_i;
              wff_q  <= 1'b0;
              pend_q <= 1'b1;
            end
          end
        endcase
      end

      if (ctrl_wr_i) begin
        acc_q  <= acc_i;
        rate_q <= rate_i;
        wff_q  <= 1'b0;
        rff_q  <= 1'b0;
        lat_q  <= 1'b0;
        run_q  <= 1'b0;
        pend_q <= 1'b0;
        out_q  <= rate_i;
      end
    end
  end

  assign rd_val  = lat_q ? latv_q : cnt_q;
  assign rd_hi   = (acc_q == ACC_HI) || ((acc_q == ACC_WORD) && rff_q);
  assign rdata_o = rd_hi ? rd_val[CNT_W-1:BYTE_W] : rd_val[BYTE_W-1:0];
  assign out_o   = out_q;

  assert_out_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rate_q && out_q && !ctrl_wr_i && !data_wr_i) |=> out_q);

  assert_rate_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_q && run_q && !out_q && tick_en_i && !ctrl_wr_i && !data_wr_i) |=> out_q);

  assert_latch_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q && !data_rd_i && !ctrl_wr_i) |=> (lat_q && $stable(latv_q)));

  assert_hold_no_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_en_i && !ctrl_wr_i) |=> $stable(cnt_q));

  assert_ctrl_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> (!run_q && !pend_q && !wff_q && !lat_q));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import pit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              gate2_i,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] out_o
);
  logic [NUM_CH-1:0]             ctrl_wr, latch, data_wr, data_rd, tick_en;
  logic [NUM_CH-1:0][BYTE_W-1:0] ch_rdata;
  acc_e                          acc;
  logic                          rate;

  pit_decode u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .wdata_i   (wdata_i),
    .ctrl_wr_o (ctrl_wr),
    .latch_o   (latch),
    .data_wr_o (data_wr),
    .data_rd_o (data_rd),
    .acc_o     (acc),
    .rate_o    (rate)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    if (i == GATED_CH) begin : g_gated
      assign tick_en[i] = tick_i && gate2_i;
    end else begin : g_free
      assign tick_en[i] = tick_i;
    end

    pit_channel u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_en_i (tick_en[i]),
      .ctrl_wr_i (ctrl_wr[i]),
      .acc_i     (acc),
      .rate_i    (rate),
      .latch_i   (latch[i]),
      .data_wr_i (data_wr[i]),
      .data_rd_i (data_rd[i]),
      .wdata_i   (wdata_i),
      .rdata_o   (ch_rdata[i]),
      .out_o     (out_o[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL) rdata_o[OUT_BIT] = out_o[GATED_CH];
    else                     rdata_o = ch_rdata[addr_i];
  end
endmodule

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, gate2 = 1'b1, wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [2:0] out;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  interval_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .gate2_i(gate2),
    .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(rdata), .out_o(out)
  );

  // behavioural reference model
  int m_cnt[3], m_rld[3], m_pend[3], m_run[3], m_out[3], m_rate[3];
  int m_acc[3], m_wff[3], m_rff[3], m_lat[3], m_latv[3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) begin
        m_cnt[c] = 0; m_rld[c] = 0; m_pend[c] = 0; m_run[c] = 0; m_out[c] = 0;
        m_rate[c] = 0; m_acc[c] = 3; m_wff[c] = 0; m_rff[c] = 0; m_lat[c] = 0; m_latv[c] = 0;
      end
    end else begin
      for (int c = 0; c < 3; c++) begin
        int oc, opend, orun, olat, orff, owff;
        bit te, cw, lt, dw, dr;
        oc = m_cnt[c]; opend = m_pend[c]; orun = m_run[c];
        olat = m_lat[c]; orff = m_rff[c]; owff = m_wff[c];
        te = tick && (c != 2 || gate2);
        cw = wr && addr == 3 && wdata[7:6] == c && wdata[5:4] != 0;
        lt = wr && addr == 3 && ((wdata[7:6] == c && wdata[5:4] == 0) ||
             (wdata[7:6] == 3 && !wdata[5] && wdata[c+1]));
        dw = wr && addr == c;
        dr = rd && addr == c;
        if (te) begin
          if (opend) begin m_cnt[c] = m_rld[c]; m_pend[c] = 0; m_run[c] = 1; end
          else if (orun) begin
            if (m_rate[c]) begin
              if (oc == 1) begin m_cnt[c] = m_rld[c]; m_out[c] = 1; end
              else begin m_cnt[c] = (oc + 65535) % 65536; if (oc == 2) m_out[c] = 0; end
            end else begin
              m_cnt[c] = (oc + 65535) % 65536;
              if (oc == 1) m_out[c] = 1;
            end
          end
        end
        if (lt && !olat) begin m_lat[c] = 1; m_latv[c] = oc; end
        if (dr) begin
          if (m_acc[c] == 3) begin m_rff[c] = 1 - orff; if (orff) m_lat[c] = 0; end
          else m_lat[c] = 0;
        end
        if (dw) begin
          m_out[c] = m_rate[c];
          if (m_acc[c] == 1) begin m_rld[c] = wdata; m_pend[c] = 1; m_run[c] = 0; end
          else if (m_acc[c] == 2) begin m_rld[c] = wdata * 256; m_pend[c] = 1; m_run[c] = 0; end
          else if (!owff) begin
            m_rld[c] = (m_rld[c] & 16'hFF00) | wdata; m_wff[c] = 1; m_pend[c] = 0; m_run[c] = 0;
          end else begin
            m_rld[c] = (m_rld[c] & 16'h00FF) | (wdata * 256); m_wff[c] = 0; m_pend[c] = 1;
          end
        end
        if (cw) begin
          m_acc[c] = wdata[5:4]; m_rate[c] = (wdata[3:1] == 2);
          m_wff[c] = 0; m_rff[c] = 0; m_lat[c] = 0; m_run[c] = 0; m_pend[c] = 0;
          m_out[c] = m_rate[c];
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // per-clock output comparison against the model (R3, R4, R5)
  always begin
    @(posedge clk);
    #2;
    if (rst_n && !done)
      for (int c = 0; c < 3; c++) chk("R4/R5 out_o vs model", out[c], m_out[c]);
  end

  task automatic wr_b(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] e, input string req);
    addr = a; rd = 1'b1;
    #1;
    chk(req, rdata, e);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic tick_n(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic meas(input int c, output int n);
    n = 0; tick = 1'b1;
    while (!out[c] && n < 70000) begin @(negedge clk); n++; end
    tick = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 out_o in reset", out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_o after reset", out, 0);
    rd_chk(2'd3, 8'h00, "R1 ctrl read after reset");

    // R3/R4: one-shot count 5
    wr_b(3, 8'h30); wr_b(0, 8'h05); wr_b(0, 8'h00);
    chk("R4 out low after programming", out[0], 0);
    meas(0, n);
    chk("R3 terminal edge tick count", n, 6);
    tick_n(20);
    chk("R4 out stays high", out[0], 1);
    wr_b(3, 8'h30);
    chk("R4 ctrl write drives out low", out[0], 0);

    // R2: BCD ignored, other modes one-shot
    wr_b(3, 8'h31); wr_b(0, 8'h10); wr_b(0, 8'h00);
    meas(0, n);
    chk("R2 BCD flag ignored, binary count", n, 17);
    wr_b(3, 8'h36);
    chk("R2 mode 3 holds low like one-shot", out[0], 0);
    wr_b(0, 8'h02); wr_b(0, 8'h00);
    meas(0, n);
    chk("R2 mode 3 expires like one-shot", n, 3);
    tick_n(6);
    chk("R2 mode 3 no reload", out[0], 1);

    // R5: rate mode on channel 1, period 4
    wr_b(3, 8'h74);
    chk("R5 out high after ctrl", out[1], 1);
    wr_b(1, 8'h04); wr_b(1, 8'h00);
    tick = 1'b1; n = 0;
    while (out[1] && n < 100) begin @(negedge clk); n++; end
    chk("R5 first low after N-1 ticks past load", n, 4);
    @(negedge clk);
    chk("R5 low lasts one tick", out[1], 1);
    n = 0;
    while (out[1] && n < 100) begin @(negedge clk); n++; end
    chk("R5 period in ticks", n + 1, 4);
    tick = 1'b0;

    // R7/R12: latch ch0
    wr_b(3, 8'h30); wr_b(0, 8'h34); wr_b(0, 8'h12);
    tick_n(1);
    wr_b(3, 8'h00);
    tick_n(5);
    rd_chk(0, 8'h34, "R7 latched low byte");
    rd_chk(0, 8'h12, "R7 latched high byte");
    rd_chk(0, 8'h2F, "R12 live low byte after release");
    rd_chk(0, 8'h12, "R12 live high byte");

    // R8: read-back on channel 2
    wr_b(3, 8'hB0); wr_b(2, 8'h00); wr_b(2, 8'h01);
    tick_n(1);
    wr_b(3, 8'hD8);
    tick_n(3);
    wr_b(3, 8'hD8);
    tick_n(2);
    rd_chk(2, 8'h00, "R8 read-back latched low");
    rd_chk(2, 8'h01, "R8 second latch ignored, high");
    rd_chk(2, 8'hFB, "R8 live after release low");
    rd_chk(2, 8'h00, "R8 live high");

    // R9: gate
    gate2 = 1'b0;
    tick_n(10);
    rd_chk(2, 8'hFB, "R9 gate low holds count low");
    rd_chk(2, 8'h00, "R9 gate low holds count high");
    gate2 = 1'b1;
    tick_n(1);
    rd_chk(2, 8'hFA, "R9 gate high counts");
    rd_chk(2, 8'h00, "R9 gate high high byte");

    // R10: channel 2 output readable
    wr_b(3, 8'hB0); wr_b(2, 8'h03); wr_b(2, 8'h00);
    rd_chk(3, 8'h00, "R10 bit5 low before expiry");
    tick_n(4);
    rd_chk(3, 8'h20, "R10 bit5 high after expiry");
    chk("R10 out_o[2]", out[2], 1);

    // R11: single-byte access modes
    wr_b(3, 8'h10); wr_b(0, 8'h07);
    tick_n(1);
    rd_chk(0, 8'h07, "R11 low-only read");
    rd_chk(0, 8'h07, "R11 low-only read repeat");
    wr_b(3, 8'h20); wr_b(0, 8'h01);
    tick_n(1);
    rd_chk(0, 8'h01, "R11 high-only read");
    wr_b(3, 8'h00);
    tick_n(2);
    rd_chk(0, 8'h01, "R11 high-only latched read");
    wr_b(3, 8'h00);
    rd_chk(0, 8'h00, "R11 latch released after one read");

    // R6: zero count in one-shot
    wr_b(3, 8'h30); wr_b(0, 8'h00); wr_b(0, 8'h00);
    meas(0, n);
    chk("R6 zero count length", n, 65537);

    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule